// File: doc/BRIEF.md
# Data-Side Micro Translation Buffer

This block is a four-slot, fully associative translation cache for data addresses. It sits in front of a larger shared translation table. Each slot maps one 4KB page. A lookup presents a 20-bit virtual page number and an 8-bit address space identifier. In the same cycle the block answers with a hit, a 24-bit physical frame number, a writable (dirty) bit and a 3-bit coherency attribute. It runs by itself, alongside the instruction-side translation buffer, and software cannot read or write it.

On a miss the block latches the missing page and asks the shared table for it through a request/valid handshake. The lookup stalls while that request is outstanding. When the response arrives, the block writes it into a victim slot chosen by a two-level pseudo-LRU tree. The access then repeats its lookup in the following cycle and hits. A response that describes a larger page is cut down to the 4KB slice that covers the missing address.

A flush pulse empties the buffer in one cycle. The flush must be given whenever the shared table changes. A flush that lands while a request is outstanding also causes the response to that request to be thrown away.

The control is a three-state machine:
- **LOOK**: answers lookups. A lookup that misses moves it to WAIT.
- **WAIT**: a request is outstanding. A response without a flush installs the entry and returns to LOOK. A flush together with a response returns to LOOK without installing. A flush alone moves to DRAIN.
- **DRAIN**: the request is still outstanding but its answer is stale. The response returns the machine to LOOK without installing.

Top module: `utlb_data`

## Requirements
- R1: A lookup (`lk_valid`=1) in state LOOK that matches a valid slot raises `lk_hit` in the same cycle. In that cycle `lk_pfn`, `lk_attr` and `lk_dirty` carry the installed values and `rf_req` stays low.
- R2: A slot matches only when both the virtual page number and the address space identifier are equal. The same page under a different identifier misses.
- R3: A lookup that misses in LOOK gives `lk_hit`=0 and `lk_stall`=1. From the next cycle on, `rf_req` is 1 and `rf_vpn`/`rf_asid` show the missing page. Both stay unchanged until a cycle with `rf_valid`=1.
- R4: A response in WAIT without a flush installs the mapping. The lookup of the same page in the next cycle hits with the response's frame, attribute and dirty bit.
- R5: `rf_size` code k (0..6) describes a page of 4KB·4^k. Any code above 6 acts as 6. The installed frame is `rf_pfn` with its low 2k bits replaced by the low 2k bits of the missing page number. A neighbouring 4KB page of the same large page therefore still misses.
- R6: The victim is the slot {root, half[root]}, where bit 1 of a slot index selects the half. Starting from reset, four fills land in slots 0, 2, 1, 3 in that order.
- R7: Every hit and every fill of slot i sets root to the opposite of index bit 1 and sets half[bit 1] to the opposite of index bit 0. A slot in use is therefore not the next victim.
- R8: `fl_flush` invalidates every slot and clears the tree in one cycle. From the next cycle on, every earlier mapping misses.
- R9: A flush while a request is outstanding discards the response to that request. The repeated lookup misses again, issues a new request, and installs the new response.
- R10: `lk_stall` equals `lk_valid` and not `lk_hit`. `lk_pfn`, `lk_attr` and `lk_dirty` are zero whenever `lk_hit` is 0.
- R11: After reset the state is LOOK with all slots invalid. `rf_req` is 1 exactly in WAIT and DRAIN, and `lk_hit` is never 1 while `rf_req` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup present |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_asid | input | 8 | Address space identifier of the lookup |
| lk_hit | output | 1 | Translation found this cycle |
| lk_stall | output | 1 | Lookup must be held and repeated |
| lk_pfn | output | 24 | Physical frame number on hit |
| lk_attr | output | 3 | Coherency attribute on hit |
| lk_dirty | output | 1 | Writable bit on hit |
| fl_flush | input | 1 | Invalidate all slots |
| rf_req | output | 1 | Refill request to the shared table |
| rf_vpn | output | 20 | Page number being requested |
| rf_asid | output | 8 | Identifier being requested |
| rf_valid | input | 1 | Refill response present |
| rf_pfn | input | 24 | Base frame number of the response |
| rf_size | input | 3 | Page size code of the response |
| rf_attr | input | 3 | Coherency attribute of the response |
| rf_dirty | input | 1 | Writable bit of the response |

## Verification
The first stream fills an empty buffer and then hits it again, with refill latencies of zero and of several cycles. This separates the single-cycle answer from the stalled path and shows whether the request is held. The same page is then asked for under a second identifier, and neighbouring pages of one large page are also asked for. These patterns tell a full tag compare from a page-only compare, and a sliced large-page install from one that covers the whole large page. A run of hits between fills steers the tree, so the evicted slot shows whether hits update it. Flushes are given both while idle and in the middle of a refill, which tells an invalidation that drops a stale response from one that lets it in.

// File: rtl/utlb_pkg.sv
package utlb_pkg;

    typedef enum logic [1:0] {
        ST_LOOK  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_DRAIN = 2'd2
    } utlb_st_e;

endpackage

// File: rtl/utlb_plru.sv
// Two-level pseudo-LRU tree over four slots; bit 1 of an index is the half.
module utlb_plru (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       use_en,
    input  logic [1:0] use_idx,
    output logic [1:0] victim
);
    logic       root_q;
    logic [1:0] half_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            root_q <= 1'b0;
            half_q <= 2'b00;
        end else if (clr) begin
            root_q <= 1'b0;
            half_q <= 2'b00;
        end else if (use_en) begin
            root_q              <= ~use_idx[1];
            half_q[use_idx[1]]  <= ~use_idx[0];
        end
    end

    assign victim = {root_q, half_q[root_q]};
endmodule

// File: rtl/utlb_pfn_slice.sv
// Picks the 4KB frame inside a larger page: low 2k frame bits come from the page number.
module utlb_pfn_slice #(
    parameter int VPN_W    = 20,
    parameter int PFN_W    = 24,
    parameter int SIZE_W   = 3,
    parameter int MAX_SIZE = 6
) (
    input  logic [PFN_W-1:0]  base_pfn,
    input  logic [VPN_W-1:0]  vpn,
    input  logic [SIZE_W-1:0] size,
    output logic [PFN_W-1:0]  pfn
);
    localparam int MASK_BITS = 2 * MAX_SIZE;

    logic [PFN_W-1:0] mask;
    logic [PFN_W-1:0] vpn_ext;
    int               eff;

    always_comb begin
        eff = (int'(size) > MAX_SIZE) ? MAX_SIZE : int'(size);
        mask = '0;
        for (int b = 0; b < MASK_BITS; b++) begin
            if (b < 2 * eff) mask[b] = 1'b1;
        end
        vpn_ext = PFN_W'(vpn);
        pfn = (base_pfn & ~mask) | (vpn_ext & mask);
    end
endmodule

// File: rtl/utlb_cam.sv
// Slot storage with parallel tag comparators and an AND-OR read port.
module utlb_cam #(
    parameter int ENTRIES = 4,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 8,
    parameter int PFN_W   = 24,
    parameter int ATTR_W  = 3,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic [ATTR_W-1:0] wr_attr,
    input  logic              wr_dirty,
    input  logic [VPN_W-1:0]  q_vpn,
    input  logic [ASID_W-1:0] q_asid,
    output logic [ENTRIES-1:0] hit_vec,
    output logic [IDX_W-1:0]  hit_idx,
    output logic [PFN_W-1:0]  rd_pfn,
    output logic [ATTR_W-1:0] rd_attr,
    output logic              rd_dirty
);
    logic [ENTRIES-1:0] v_q;
    logic [VPN_W-1:0]   vpn_q   [ENTRIES];
    logic [ASID_W-1:0]  asid_q  [ENTRIES];
    logic [PFN_W-1:0]   pfn_q   [ENTRIES];
    logic [ATTR_W-1:0]  attr_q  [ENTRIES];
    logic [ENTRIES-1:0] dirty_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q     <= '0;
            dirty_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                vpn_q[i]  <= '0;
                asid_q[i] <= '0;
                pfn_q[i]  <= '0;
                attr_q[i] <= '0;
            end
        end else if (flush) begin
            v_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (wr_idx == IDX_W'(i)) begin
                    v_q[i]     <= 1'b1;
                    vpn_q[i]   <= wr_vpn;
                    asid_q[i]  <= wr_asid;
                    pfn_q[i]   <= wr_pfn;
                    attr_q[i]  <= wr_attr;
                    dirty_q[i] <= wr_dirty;
                end
            end
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = v_q[g] && (vpn_q[g] == q_vpn) && (asid_q[g] == q_asid);
    end

    always_comb begin
        hit_idx  = '0;
        rd_pfn   = '0;
        rd_attr  = '0;
        rd_dirty = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
            rd_pfn   = rd_pfn  | (pfn_q[i]  & {PFN_W{hit_vec[i]}});
            rd_attr  = rd_attr | (attr_q[i] & {ATTR_W{hit_vec[i]}});
            rd_dirty = rd_dirty | (dirty_q[i] & hit_vec[i]);
        end
    end
endmodule

// File: rtl/utlb_data.sv
module utlb_data #(
    parameter int VPN_W    = 20,
    parameter int ASID_W   = 8,
    parameter int PFN_W    = 24,
    parameter int ATTR_W   = 3,
    parameter int SIZE_W   = 3,
    parameter int MAX_SIZE = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic              lk_stall,
    output logic [PFN_W-1:0]  lk_pfn,
    output logic [ATTR_W-1:0] lk_attr,
    output logic              lk_dirty,
    input  logic              fl_flush,
    output logic              rf_req,
    output logic [VPN_W-1:0]  rf_vpn,
    output logic [ASID_W-1:0] rf_asid,
    input  logic              rf_valid,
    input  logic [PFN_W-1:0]  rf_pfn,
    input  logic [SIZE_W-1:0] rf_size,
    input  logic [ATTR_W-1:0] rf_attr,
    input  logic              rf_dirty
);
    import utlb_pkg::*;

    localparam int ENTRIES = 4;
    localparam int IDX_W   = $clog2(ENTRIES);

    utlb_st_e          st_q, st_d;
    logic [VPN_W-1:0]  miss_vpn_q;
    logic [ASID_W-1:0] miss_asid_q;

    logic [ENTRIES-1:0] hit_vec;
    logic [IDX_W-1:0]   hit_idx, victim;
    logic [PFN_W-1:0]   rd_pfn, fill_pfn;
    logic [ATTR_W-1:0]  rd_attr;
    logic               rd_dirty;
    logic               cam_hit, look_hit, look_miss, fill_en;

    assign cam_hit   = |hit_vec;
    assign look_hit  = lk_valid && cam_hit && (st_q == ST_LOOK);
    assign look_miss = lk_valid && !cam_hit && (st_q == ST_LOOK);
    assign fill_en   = (st_q == ST_WAIT) && rf_valid && !fl_flush;

    utlb_cam #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W),
        .PFN_W(PFN_W), .ATTR_W(ATTR_W)
    ) u_cam (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (fl_flush),
        .wr_en    (fill_en),
        .wr_idx   (victim),
        .wr_vpn   (miss_vpn_q),
        .wr_asid  (miss_asid_q),
        .wr_pfn   (fill_pfn),
        .wr_attr  (rf_attr),
        .wr_dirty (rf_dirty),
        .q_vpn    (lk_vpn),
        .q_asid   (lk_asid),
        .hit_vec  (hit_vec),
        .hit_idx  (hit_idx),
        .rd_pfn   (rd_pfn),
        .rd_attr  (rd_attr),
        .rd_dirty (rd_dirty)
    );

    utlb_plru u_plru (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (fl_flush),
        .use_en  (look_hit || fill_en),
        .use_idx (fill_en ? victim : hit_idx),
        .victim  (victim)
    );

    utlb_pfn_slice #(
        .VPN_W(VPN_W), .PFN_W(PFN_W), .SIZE_W(SIZE_W), .MAX_SIZE(MAX_SIZE)
    ) u_slice (
        .base_pfn (rf_pfn),
        .vpn      (miss_vpn_q),
        .size     (rf_size),
        .pfn      (fill_pfn)
    );

    // State register and miss latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= ST_LOOK;
            miss_vpn_q  <= '0;
            miss_asid_q <= '0;
        end else begin
            st_q <= st_d;
            if (look_miss) begin
                miss_vpn_q  <= lk_vpn;
                miss_asid_q <= lk_asid;
            end
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_LOOK:  if (look_miss) st_d = ST_WAIT;
            ST_WAIT: begin
                if (rf_valid)      st_d = ST_LOOK;
                else if (fl_flush) st_d = ST_DRAIN;
            end
            ST_DRAIN: if (rf_valid) st_d = ST_LOOK;
            default:  st_d = ST_LOOK;
        endcase
    end

    // Outputs
    always_comb begin
        lk_hit   = look_hit;
        lk_stall = lk_valid && !look_hit;
        lk_pfn   = look_hit ? rd_pfn : '0;
        lk_attr  = look_hit ? rd_attr : '0;
        lk_dirty = look_hit && rd_dirty;
        rf_req   = 1'b0;
        unique case (st_q)
            ST_LOOK:  rf_req = 1'b0;
            ST_WAIT:  rf_req = 1'b1;
            ST_DRAIN: rf_req = 1'b1;
            default:  rf_req = 1'b0;
        endcase
        rf_vpn  = miss_vpn_q;
        rf_asid = miss_asid_q;
    end
endmodule

// File: rtl/utlb_data_chk.sv
module utlb_data_chk #(
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [VPN_W-1:0]  lk_vpn,
    input logic [ASID_W-1:0] lk_asid,
    input logic              lk_hit,
    input logic              fl_flush,
    input logic              rf_req,
    input logic [VPN_W-1:0]  rf_vpn,
    input logic [ASID_W-1:0] rf_asid,
    input logic              rf_valid,
    input utlb_pkg::utlb_st_e st,
    input logic [3:0]        hit_vec
);
    import utlb_pkg::*;

    p_single_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    p_miss_requests_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_hit && !rf_req) |=> rf_req);

    p_req_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_req && !rf_valid) |=> (rf_req && $stable(rf_vpn) && $stable(rf_asid)));

    p_retry_hits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT && rf_valid && !fl_flush) |=>
        (!(lk_valid && lk_vpn == $past(rf_vpn) && lk_asid == $past(rf_asid)) || lk_hit));

    p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fl_flush |=> !lk_hit);

    p_no_hit_in_refill_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rf_req |-> !lk_hit);
endmodule

bind utlb_data utlb_data_chk #(.VPN_W(VPN_W), .ASID_W(ASID_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_valid (lk_valid),
    .lk_vpn   (lk_vpn),
    .lk_asid  (lk_asid),
    .lk_hit   (lk_hit),
    .fl_flush (fl_flush),
    .rf_req   (rf_req),
    .rf_vpn   (rf_vpn),
    .rf_asid  (rf_asid),
    .rf_valid (rf_valid),
    .st       (st_q),
    .hit_vec  (u_cam.hit_vec)
);

// File: tb/utlb_data_bench.sv
`timescale 1ns/1ps
module utlb_data_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_hit, lk_stall, lk_dirty;
    logic [23:0] lk_pfn;
    logic [2:0]  lk_attr;
    logic        fl_flush = 1'b0;
    logic        rf_req;
    logic [19:0] rf_vpn;
    logic [7:0]  rf_asid;
    logic        rf_valid = 1'b0;
    logic [23:0] rf_pfn = '0;
    logic [2:0]  rf_size = '0;
    logic [2:0]  rf_attr = '0;
    logic        rf_dirty = 1'b0;

    int errors = 0;
    int checks = 0;

    typedef struct {
        bit          hit;
        logic [23:0] pfn;
        logic [2:0]  attr;
        bit          dirty;
        string       rq;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    utlb_data u_utlb_data (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
        .lk_hit(lk_hit), .lk_stall(lk_stall), .lk_pfn(lk_pfn), .lk_attr(lk_attr),
        .lk_dirty(lk_dirty), .fl_flush(fl_flush), .rf_req(rf_req), .rf_vpn(rf_vpn),
        .rf_asid(rf_asid), .rf_valid(rf_valid), .rf_pfn(rf_pfn), .rf_size(rf_size),
        .rf_attr(rf_attr), .rf_dirty(rf_dirty)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic push(input bit hit, input logic [23:0] pfn, input logic [2:0] attr,
                        input bit dirty, input string rq);
        exp_t e;
        e.hit = hit; e.pfn = pfn; e.attr = attr; e.dirty = dirty; e.rq = rq;
        sb.push_back(e);
    endtask

    // Monitor: one expected item per lookup cycle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (lk_valid) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R1 unexpected lookup", {31'd0, lk_hit}, 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(lk_hit == e.hit, {e.rq, " hit"}, {31'd0, lk_hit}, {31'd0, e.hit});
                    chk(lk_stall == !e.hit, "R10 stall", {31'd0, lk_stall}, {31'd0, !e.hit});
                    if (e.hit) begin
                        chk(lk_pfn == e.pfn, {e.rq, " pfn"}, {8'd0, lk_pfn}, {8'd0, e.pfn});
                        chk(lk_attr == e.attr && lk_dirty == e.dirty, {e.rq, " attr/dirty"},
                            {28'd0, lk_dirty, lk_attr}, {28'd0, e.dirty, e.attr});
                    end else begin
                        chk(lk_pfn == '0 && lk_attr == '0 && !lk_dirty, "R10 zero on miss",
                            {4'd0, lk_dirty, lk_attr, lk_pfn}, 32'd0);
                    end
                end
            end
        end
    end

    task automatic hit_one(input logic [19:0] vpn, input logic [7:0] asid,
                           input logic [23:0] pfn, input logic [2:0] attr,
                           input bit dirty, input string rq);
        @(negedge clk);
        lk_valid = 1'b1; lk_vpn = vpn; lk_asid = asid;
        push(1'b1, pfn, attr, dirty, rq);
        #1;
        chk(!rf_req, "R1 no request on hit", {31'd0, rf_req}, 32'd0);
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic miss_fill(input logic [19:0] vpn, input logic [7:0] asid, input int lat,
                             input logic [23:0] base, input logic [2:0] size,
                             input logic [2:0] attr, input bit dirty,
                             input logic [23:0] exp_pfn, input string rq);
        @(negedge clk);
        lk_valid = 1'b1; lk_vpn = vpn; lk_asid = asid;
        push(1'b0, '0, '0, 1'b0, {rq, " miss"});
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            push(1'b0, '0, '0, 1'b0, "R3 stall");
            #1;
            chk(rf_req && rf_vpn == vpn && rf_asid == asid, "R3 request held",
                {3'd0, rf_req, rf_asid, rf_vpn}, {3'd0, 1'b1, asid, vpn});
        end
        @(negedge clk);
        push(1'b0, '0, '0, 1'b0, "R3 stall");
        rf_valid = 1'b1; rf_pfn = base; rf_size = size; rf_attr = attr; rf_dirty = dirty;
        #1;
        chk(rf_req && rf_vpn == vpn && rf_asid == asid, "R3 request",
            {3'd0, rf_req, rf_asid, rf_vpn}, {3'd0, 1'b1, asid, vpn});
        @(negedge clk);
        rf_valid = 1'b0;
        push(1'b1, exp_pfn, attr, dirty, {rq, " R4 retry"});
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!lk_hit && !rf_req && !lk_stall, "R11 reset state",
            {29'd0, lk_hit, rf_req, lk_stall}, 32'd0);

        // R6 fill order 0,2,1,3; R2 identifier in tag; R5 large page slices
        miss_fill(20'h12345, 8'd5, 0, 24'h0ABCDE, 3'd0, 3'd3, 1'b1, 24'h0ABCDE, "R1");
        hit_one(20'h12345, 8'd5, 24'h0ABCDE, 3'd3, 1'b1, "R1 repeat");
        miss_fill(20'h12345, 8'd6, 2, 24'h000111, 3'd0, 3'd1, 1'b0, 24'h000111, "R2");
        miss_fill(20'h40123, 8'd5, 0, 24'h555550, 3'd2, 3'd2, 1'b0, 24'h555553, "R5");
        miss_fill(20'h40124, 8'd5, 1, 24'h555550, 3'd2, 3'd2, 1'b0, 24'h555554, "R5 neighbour");
        // Slot of tag 6 is victim after hitting slot 0 (R7)
        hit_one(20'h12345, 8'd5, 24'h0ABCDE, 3'd3, 1'b1, "R7 hit");
        miss_fill(20'h00777, 8'd5, 0, 24'h00CAFE, 3'd0, 3'd4, 1'b1, 24'h00CAFE, "R6");
        hit_one(20'h12345, 8'd5, 24'h0ABCDE, 3'd3, 1'b1, "R6 kept");
        hit_one(20'h40124, 8'd5, 24'h555554, 3'd2, 1'b0, "R7 kept");
        hit_one(20'h00777, 8'd5, 24'h00CAFE, 3'd4, 1'b1, "R7 kept");
        // Evicted mapping misses again; it lands in slot 1, evicting 0x40123
        miss_fill(20'h12345, 8'd6, 0, 24'h000111, 3'd0, 3'd1, 1'b0, 24'h000111, "R6 evicted");
        miss_fill(20'h40123, 8'd5, 0, 24'h555550, 3'd2, 3'd2, 1'b0, 24'h555553, "R6 evicted");
        hit_one(20'h00777, 8'd5, 24'h00CAFE, 3'd4, 1'b1, "R7 kept");
        // Size code above maximum acts as 16MB
        miss_fill(20'hABCDE, 8'd9, 0, 24'h123000, 3'd7, 3'd0, 1'b0, 24'h123CDE, "R5 clamp");

        // R8 idle flush
        @(negedge clk);
        fl_flush = 1'b1;
        @(negedge clk);
        fl_flush = 1'b0;
        miss_fill(20'h00777, 8'd5, 0, 24'h00BEE0, 3'd0, 3'd5, 1'b0, 24'h00BEE0, "R8 flushed");

        // R9 flush during outstanding request
        @(negedge clk);
        lk_valid = 1'b1; lk_vpn = 20'h00999; lk_asid = 8'd3;
        push(1'b0, '0, '0, 1'b0, "R9 miss");
        @(negedge clk);
        push(1'b0, '0, '0, 1'b0, "R9 wait");
        fl_flush = 1'b1;
        @(negedge clk);
        fl_flush = 1'b0;
        push(1'b0, '0, '0, 1'b0, "R9 drain");
        #1;
        chk(rf_req, "R9 request still out", {31'd0, rf_req}, 32'd1);
        rf_valid = 1'b1; rf_pfn = 24'h0DEAD0; rf_attr = 3'd7; rf_dirty = 1'b1; rf_size = 3'd0;
        @(negedge clk);
        rf_valid = 1'b0;
        push(1'b0, '0, '0, 1'b0, "R9 stale dropped");
        #1;
        chk(!rf_req, "R11 back in LOOK", {31'd0, rf_req}, 32'd0);
        @(negedge clk);
        push(1'b0, '0, '0, 1'b0, "R9 new request");
        #1;
        chk(rf_req && rf_vpn == 20'h00999, "R9 reissued", {11'd0, rf_req, rf_vpn}, {11'd0, 1'b1, 20'h00999});
        rf_valid = 1'b1; rf_pfn = 24'h0BEEF0; rf_attr = 3'd2; rf_dirty = 1'b0;
        @(negedge clk);
        rf_valid = 1'b0;
        push(1'b1, 24'h0BEEF0, 3'd2, 1'b0, "R9 fresh install");
        @(negedge clk);
        lk_valid = 1'b0;

        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R1 scoreboard drained", sb.size(), 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule